// File: doc/BRIEF.md
# Multidrop 9-bit Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for nodes on a shared multidrop line. It has three framing modes. One sends 8 data bits and runs at a rate set from outside. Two send 9 bits, where the ninth bit marks a frame as an address or as data. One 9-bit mode runs at a rate set from outside. The other divides the system clock by 64, or by 32 when the double-speed input is high. In the modes with an outside rate, `baud_tick_i` supplies one pulse per sixteenth of a bit.

Software drives the port through an 8-bit control word and a byte buffer. Writing the buffer sends a frame. A received frame is placed in the buffer, and the receive flag is raised. A node that sets its address-filter bit stays quiet while data frames pass on the bus. The receiver raises its flag only for frames whose ninth bit is 1. In the 8-bit mode, the filter instead drops frames that end in a bad stop bit. Hardware only ever sets the two flags, and software clears them.

Top module: `mp_uart`

## Requirements
- R1: After reset `txd_o` is 1, and both the control word and the received byte read 0.
- R2: A control write stores all 8 bits, which read back unchanged. The layout from bit 7 down is: mode[1], mode[0], address-filter enable, receive enable, TX ninth bit, RX ninth bit, transmit flag, receive flag.
- R3: A buffer write in mode 01, 10 or 11 sends the following bits, each on the line for 16 ticks: a 0 start bit, then 8 data bits LSB first, then in modes 10 and 11 the TX ninth bit from control bit 3, then a 1 stop bit.
- R4: The transmit flag (bit 1) sets once the stop bit has been sent. A buffer write during a frame is ignored and does not queue a second frame.
- R5: In mode 10 a bit lasts 64 system clocks when `dbl_speed_i` is 0 and 32 clocks when it is 1.
- R6: In modes 01 and 11 a bit lasts 16 pulses of `baud_tick_i`.
- R7: A falling edge on `rxd_i` starts reception only while receive enable (bit 4) is 1. Each bit value is the majority of samples 7, 8 and 9 out of 16. A start bit that votes high is dropped as a false start.
- R8: In modes 10 and 11 the received ninth bit goes to control bit 2. With address-filter enable (bit 5) set, a frame whose ninth bit is 0 leaves the flag and the buffer unchanged.
- R9: In mode 01 control bit 2 receives the stop bit. With the filter clear, a frame with a 0 stop bit is still accepted. With the filter set, such a frame is dropped.
- R10: While the receive flag is 1, a newly completed frame is dropped and the buffer keeps the old byte.
- R11: The flags clear only through a control write. Hardware never clears them.
- R12: In mode 00 buffer writes send nothing and the receiver stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Oversample tick (16 per bit) for modes 01 and 11 |
| dbl_speed_i | input | 1 | Selects divide-by-32 in mode 10 |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control word write data |
| ctrl_rdata_o | output | 8 | Control word read value |
| data_we_i | input | 1 | Buffer write strobe; starts a transmission |
| data_wdata_i | input | 8 | Byte to transmit |
| data_rdata_o | output | 8 | Last accepted received byte |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |

## Verification
The assertions assume that software changes the mode field only while the port is idle. They also assume that `baud_tick_i` pulses are at least one clock apart, so that each tick lasts a single cycle. The bench follows both rules. It reprograms the control word only between frames, and it generates external ticks as one-clock pulses every third clock. Received frames are driven at exactly 16 ticks per bit, with a gap of idle line after each frame. This keeps every assertion about flags, the held buffer and the tick spacing within the conditions it was written for.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_8V  = 2'b01,
    MODE_9F  = 2'b10,
    MODE_9V  = 2'b11
  } mode_e;

  localparam int DATA_W  = 8;
  localparam int C_MODE_HI = 7;
  localparam int C_MODE_LO = 6;
  localparam int C_FILT  = 5;
  localparam int C_RXEN  = 4;
  localparam int C_TX9   = 3;
  localparam int C_RX9   = 2;
  localparam int C_TXF   = 1;
  localparam int C_RXF   = 0;
endpackage

// File: rtl/mp_uart_tick.sv
module mp_uart_tick
  import mp_uart_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DIV_SLOW = 64,
  parameter int DIV_FAST = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  dbl_i,
  input  logic  ext_tick_i,
  output logic  tick_o
);
  localparam int PER_S = DIV_SLOW / OVS;
  localparam int PER_F = DIV_FAST / OVS;
  localparam int CW    = $clog2(PER_S + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          wrap;

  assign lim  = dbl_i ? CW'(PER_F - 1) : CW'(PER_S - 1);
  assign wrap = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (mode_i != MODE_9F) cnt_q <= '0;
    else if (wrap)             cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (mode_i == MODE_9F)       tick_o = wrap;
    else if (mode_i == MODE_OFF) tick_o = 1'b0;
    else                         tick_o = ext_tick_i;
  end

  if (PER_F > 1) begin : g_gap_chk
    assert_fix_tick_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_9F && tick_o) |=> (!tick_o || mode_i != MODE_9F));
  end
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mp_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              nine_i,
  input  logic              bit9_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CW = $clog2(OVS);
  localparam int FW = DATA_W + 3;

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q;
  logic          nine_q, busy_q, done_q;
  logic [3:0]    last;

  assign last = nine_q ? 4'(FW - 1) : 4'(FW - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      nine_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          nine_q <= nine_i;
          cnt_q  <= '0;
          idx_q  <= '0;
          sh_q   <= nine_i ? {1'b1, bit9_i, data_i, 1'b0} : {2'b11, data_i, 1'b0};
        end
      end else if (tick_i) begin
        if (cnt_q == CW'(OVS - 1)) begin
          cnt_q <= '0;
          if (idx_q == last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= {1'b1, sh_q[FW-1:1]};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // a new write must not disturb a frame in flight
  assert_hold_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !tick_i) |=> $stable(sh_q));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              rxd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              stop_o
);
  localparam int CW = $clog2(OVS);
  localparam int S1 = OVS / 2 - 2;
  localparam int S2 = OVS / 2 - 1;
  localparam int S3 = OVS / 2;

  logic              s1_q, s2_q, s3_q;
  logic              busy_q, nine_q, v1_q, v2_q, valid_q, b9_q, stop_q;
  logic [CW-1:0]     cnt_q;
  logic [3:0]        idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              maj;

  assign maj = (v1_q & v2_q) | (v1_q & s2_q) | (v2_q & s2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1; s2_q <= 1'b1; s3_q <= 1'b1;
      busy_q <= 1'b0; nine_q <= 1'b0;
      v1_q <= 1'b1; v2_q <= 1'b1;
      valid_q <= 1'b0; b9_q <= 1'b0; stop_q <= 1'b0;
      cnt_q <= '0; idx_q <= '0; sh_q <= '0;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      valid_q <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        if (s3_q && !s2_q) begin
          busy_q <= 1'b1;
          nine_q <= nine_i;
          cnt_q  <= '0;
          idx_q  <= '0;
        end
      end else if (tick_i) begin
        if (cnt_q == CW'(S1)) v1_q <= s2_q;
        if (cnt_q == CW'(S2)) v2_q <= s2_q;
        if (cnt_q == CW'(S3)) begin
          if (idx_q == 4'd0) begin
            if (maj) busy_q <= 1'b0;  // false start
          end else if (idx_q <= 4'(DATA_W)) begin
            sh_q <= {maj, sh_q[DATA_W-1:1]};
          end else if (nine_q && idx_q == 4'(DATA_W + 1)) begin
            b9_q <= maj;
          end else begin
            stop_q  <= maj;
            valid_q <= 1'b1;
            busy_q  <= 1'b0;
          end
        end
        if (cnt_q == CW'(OVS - 1)) begin
          cnt_q <= '0;
          idx_q <= idx_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = sh_q;
  assign bit9_o  = b9_q;
  assign stop_o  = stop_q;
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DIV_SLOW = 64,
  parameter int DIV_FAST = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        baud_tick_i,
  input  logic        dbl_speed_i,
  input  logic        ctrl_we_i,
  input  logic [7:0]  ctrl_wdata_i,
  output logic [7:0]  ctrl_rdata_o,
  input  logic        data_we_i,
  input  logic [7:0]  data_wdata_i,
  output logic [7:0]  data_rdata_o,
  input  logic        rxd_i,
  output logic        txd_o
);
  logic [7:0]        ctrl_q;
  logic [DATA_W-1:0] rbuf_q;
  mode_e             mode;
  logic              tick, nine;
  logic              tx_busy, tx_done, tx_start;
  logic              rx_valid, rx_b9, rx_stop, rx_ok, rx_pass;
  logic [DATA_W-1:0] rx_data;

  assign mode = mode_e'(ctrl_q[C_MODE_HI:C_MODE_LO]);
  assign nine = ctrl_q[C_MODE_HI];

  mp_uart_tick #(.OVS(OVS), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk_i, .rst_ni, .mode_i(mode), .dbl_i(dbl_speed_i),
    .ext_tick_i(baud_tick_i), .tick_o(tick)
  );

  assign tx_start = data_we_i && (mode != MODE_OFF);

  mp_uart_tx #(.OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(tx_start), .nine_i(nine),
    .bit9_i(ctrl_q[C_TX9]), .data_i(data_wdata_i), .txd_o,
    .busy_o(tx_busy), .done_o(tx_done)
  );

  mp_uart_rx #(.OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick),
    .en_i(ctrl_q[C_RXEN] && mode != MODE_OFF), .nine_i(nine), .rxd_i,
    .valid_o(rx_valid), .data_o(rx_data), .bit9_o(rx_b9), .stop_o(rx_stop)
  );

  // address filter: ninth bit in 9-bit modes, stop validity in 8-bit mode
  assign rx_pass = !ctrl_q[C_FILT] || (nine ? rx_b9 : rx_stop);
  assign rx_ok   = rx_valid && !ctrl_q[C_RXF] && rx_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rbuf_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      if (tx_done)   ctrl_q[C_TXF] <= 1'b1;
      if (rx_ok) begin
        ctrl_q[C_RXF] <= 1'b1;
        ctrl_q[C_RX9] <= nine ? rx_b9 : rx_stop;
        rbuf_q        <= rx_data;
      end
    end
  end

  assign ctrl_rdata_o = ctrl_q;
  assign data_rdata_o = rbuf_q;

  assert_rxf_sw_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q[C_RXF]) |-> $past(ctrl_we_i));
  assert_txf_sw_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q[C_TXF]) |-> $past(ctrl_we_i));
  assert_txf_after_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_q[C_TXF]) && !$past(ctrl_we_i)) |-> $past(txd_o));
  assert_hold_buf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[C_RXF] |=> $stable(rbuf_q));
  assert_addr_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_q[C_RXF]) && !$past(ctrl_we_i) && $past(ctrl_q[C_MODE_HI])
     && $past(ctrl_q[C_FILT])) |-> ctrl_q[C_RX9]);
endmodule

// File: tb/tb_mp_uart.sv
module tb_mp_uart;
  localparam int CLK_PERIOD = 10;
  localparam int TPER = 3;
  localparam int TV   = 16 * TPER;
  localparam int TF   = 64;
  localparam int TFD  = 32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       dbl_speed_i = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [7:0] ctrl_rdata_o;
  logic       data_we_i = 1'b0;
  logic [7:0] data_wdata_i = '0;
  logic [7:0] data_rdata_o;
  logic       rxd_i = 1'b1;
  logic       txd_o;
  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mp_uart dut (
    .clk_i(clk), .rst_ni, .baud_tick_i, .dbl_speed_i, .ctrl_we_i, .ctrl_wdata_i,
    .ctrl_rdata_o, .data_we_i, .data_wdata_i, .data_rdata_o, .rxd_i, .txd_o
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick_i = (c == TPER - 1);
      c = (c == TPER - 1) ? 0 : c + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we_i = 1'b1; data_wdata_i = v;
    @(negedge clk); data_we_i = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit nine, input bit b9,
                          input bit stp, input int t);
    @(negedge clk); rxd_i = 1'b0;
    repeat (t) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_i = d[i]; repeat (t) @(negedge clk); end
    if (nine) begin rxd_i = b9; repeat (t) @(negedge clk); end
    rxd_i = stp; repeat (t) @(negedge clk);
    rxd_i = 1'b1; repeat (2 * t) @(negedge clk);
  endtask

  task automatic tx_capture(input int t, input int n, output logic [10:0] bits);
    int guard = 0;
    bits = '1;
    while (txd_o !== 1'b0 && guard < 20 * t) begin @(negedge clk); guard++; end
    repeat (t / 2) @(negedge clk);
    bits[0] = txd_o;
    for (int i = 1; i < n; i++) begin repeat (t) @(negedge clk); bits[i] = txd_o; end
  endtask

  task automatic t_reset;
    chk("R1 txd", txd_o, 1);
    chk("R1 ctrl", ctrl_rdata_o, 0);
    chk("R1 data", data_rdata_o, 0);
  endtask

  task automatic t_ctrl_rw;
    wr_ctrl(8'h3C);
    chk("R2 readback", ctrl_rdata_o, 8'h3C);
    wr_ctrl(8'h00);
  endtask

  task automatic t_tx_8bit;
    logic [10:0] b;
    wr_ctrl(8'h40);
    wr_data(8'hA5);
    tx_capture(TV, 10, b);
    chk("R3 R6 frame8", b[9:0], {1'b1, 8'hA5, 1'b0});
    repeat (TV) @(negedge clk);
    chk("R4 txflag", ctrl_rdata_o[1], 1);
    wr_ctrl(8'h40);
  endtask

  task automatic t_tx_9bit;
    logic [10:0] b;
    wr_ctrl(8'hC8);
    wr_data(8'h3C);
    tx_capture(TV, 11, b);
    chk("R3 frame9", b, {2'b11, 8'h3C, 1'b0});
    repeat (TV) @(negedge clk);
    chk("R4 txflag9", ctrl_rdata_o[1], 1);
    wr_ctrl(8'hC0);
  endtask

  task automatic t_tx_busy;
    logic [10:0] b;
    int lows = 0;
    wr_ctrl(8'hC0);
    wr_data(8'h55);
    fork
      tx_capture(TV, 11, b);
      begin repeat (3 * TV) @(negedge clk); wr_data(8'hAA); end
    join
    chk("R4 busy ignore", b, {2'b10, 8'h55, 1'b0});
    repeat (TV) @(negedge clk);
    for (int i = 0; i < 3 * TV; i++) begin @(negedge clk); if (!txd_o) lows++; end
    chk("R4 no queue", lows, 0);
    wr_ctrl(8'hC0);
  endtask

  task automatic meas_bit(input bit dbl, input int exp);
    int n = 0;
    int guard = 0;
    dbl_speed_i = dbl;
    wr_ctrl(8'h80);
    wr_data(8'h01);
    while (txd_o !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    while (txd_o !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    while (txd_o === 1'b1 && n < 2000) begin @(negedge clk); n++; end
    chk(dbl ? "R5 fast bit" : "R5 slow bit", n, exp);
    repeat (11 * exp) @(negedge clk);
    wr_ctrl(8'h80);
    dbl_speed_i = 1'b0;
  endtask

  task automatic t_rx_8bit;
    wr_ctrl(8'h50);
    rx_frame(8'h96, 0, 0, 1, TV);
    chk("R9 data", data_rdata_o, 8'h96);
    chk("R9 flag", ctrl_rdata_o[0], 1);
    chk("R9 rx9 stop", ctrl_rdata_o[2], 1);
    wr_ctrl(8'h50);
    rx_frame(8'h3A, 0, 0, 0, TV);
    chk("R9 badstop accept", {ctrl_rdata_o[2], ctrl_rdata_o[0], data_rdata_o}, {2'b01, 8'h3A});
    wr_ctrl(8'h70);
    rx_frame(8'h11, 0, 0, 0, TV);
    chk("R9 badstop filtered", {ctrl_rdata_o[0], data_rdata_o}, {1'b0, 8'h3A});
    rx_frame(8'h22, 0, 0, 1, TV);
    chk("R9 goodstop filtered", {ctrl_rdata_o[0], data_rdata_o}, {1'b1, 8'h22});
    wr_ctrl(8'h70);
  endtask

  task automatic t_rx_9bit;
    wr_ctrl(8'hF0);
    rx_frame(8'h5A, 1, 0, 1, TV);
    chk("R8 data dropped", {ctrl_rdata_o[0], data_rdata_o}, {1'b0, 8'h22});
    rx_frame(8'hA1, 1, 1, 1, TV);
    chk("R8 addr taken", {ctrl_rdata_o[2], ctrl_rdata_o[0], data_rdata_o}, {2'b11, 8'hA1});
    wr_ctrl(8'hD0);
    rx_frame(8'h77, 1, 0, 1, TV);
    chk("R8 nofilter", {ctrl_rdata_o[2], ctrl_rdata_o[0], data_rdata_o}, {2'b01, 8'h77});
  endtask

  task automatic t_overrun;
    rx_frame(8'h0F, 1, 1, 1, TV);
    chk("R10 keep old", data_rdata_o, 8'h77);
    repeat (200) @(negedge clk);
    chk("R11 flag held", ctrl_rdata_o[0], 1);
    wr_ctrl(8'hD0);
    chk("R11 sw clear", ctrl_rdata_o[0], 0);
  endtask

  task automatic t_rx_gate;
    wr_ctrl(8'hC0);
    rx_frame(8'h44, 1, 1, 1, TV);
    chk("R7 rx disabled", {ctrl_rdata_o[0], data_rdata_o}, {1'b0, 8'h77});
    wr_ctrl(8'h90);
    @(negedge clk); rxd_i = 1'b0;
    repeat (3) @(negedge clk); rxd_i = 1'b1;
    repeat (2 * TF) @(negedge clk);
    chk("R7 false start", ctrl_rdata_o[0], 0);
    rx_frame(8'h6B, 1, 1, 1, TF);
    chk("R7 after glitch", {ctrl_rdata_o[0], data_rdata_o}, {1'b1, 8'h6B});
    wr_ctrl(8'h90);
  endtask

  task automatic t_mode_off;
    int lows = 0;
    wr_ctrl(8'h10);
    wr_data(8'h12);
    for (int i = 0; i < 3 * TV; i++) begin @(negedge clk); if (!txd_o) lows++; end
    chk("R12 no tx", lows, 0);
    rx_frame(8'h99, 0, 0, 1, TV);
    chk("R12 no rx", {ctrl_rdata_o[1:0], data_rdata_o}, {2'b00, 8'h6B});
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_tx_8bit();
    t_tx_9bit();
    t_tx_busy();
    meas_bit(0, TF);
    meas_bit(1, TFD);
    t_rx_8bit();
    t_rx_9bit();
    t_overrun();
    t_rx_gate();
    t_mode_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule